// File: doc/BRIEF.md
# I/O Translation Unit Configuration Register Bank

This block is the software-visible register bank of an I/O address translation unit. A processor reaches it through a word-wide read/write port that carries a byte address. Each register keeps only the bits it defines. Some registers also hold bits that read as one whatever software writes. The bank drives the translation enable, the page-table base and the start address of the translated window. The window start is derived from a three-bit range field in the control register.

The translation datapath reports a failed lookup on a capture strobe. The bank then records a fault status word and the faulting page address, and raises an interrupt. Software lowers the interrupt by reading or writing either fault register. The mask identification register collects bits: a write can set bits in it but never clear them.

The request port accepts one access on every cycle in which `req_valid` is high. It never applies back-pressure, so it has no ready signal. A read returns its data on `rsp_data` one cycle later, with `rsp_valid` high for that single cycle. The consumer must take the response in that cycle, because it cannot stall the response. The fault capture inputs and all status outputs are plain level signals.

Top module: `iommu_cfg_regs`

## Requirements
- R1: After reset the registers hold the following values: control = VERSION in bits [31:24] and zero elsewhere; fault status = 0x00800000; arbiter enable (0x1008) = 0x00000003; arbitration enable (0x2000) = 0x00000008; mask ID (0x3018) = 0x23000000; every other register = 0. After reset `irq` is low.
- R2: A write to control (0x0000) keeps the data bits under mask 0x0000001D and always reads back with VERSION in bits [31:24]. `xlate_en` equals control bit 0.
- R3: `win_start` equals 2^32 minus (16 MB shifted left by control bits [4:2]). This gives 0xFF000000 for code 0 and 0x80000000 for code 7.
- R4: A write to the page-table base (0x0004) keeps the bits under mask 0x07FFFC00. `pt_base` shows the stored value.
- R5: The two flush registers (0x0014 and 0x0018) store all 32 bits of a write unchanged.
- R6: The arbiter enable register (0x1008) keeps the bits under mask 0x801F000F, and bit 0 always reads 1.
- R7: The arbitration enable register (0x2000) keeps the bits under mask 0x001F0000, and bit 3 always reads 1.
- R8: The fault status register (0x1000) keeps the bits under mask 0xFF0FFFFF, and bit 23 always reads 1. The fault address register (0x1004) stores all 32 bits of a write.
- R9: There are NUM_SLOTS slot configuration registers, one word each, starting at 0x1010. Each keeps the bits under mask 0x00010003 and is independent of the others.
- R10: A write to mask ID (0x3018) ORs data bits [23:0] into the register. Bits never clear, and bits [31:24] never change.
- R11: When `flt_capture` is high on a clock edge, the fault status becomes 0xC0820000, or 0xC0860000 if `flt_is_read` is high. The fault address becomes `flt_addr` with bits [11:0] cleared, and `irq` is high on the next cycle. A bus write to a fault register in that same cycle is lost.
- R12: An aligned read or write of 0x1000 or 0x1004, in a cycle without a capture, drives `irq` low on the next cycle. Accesses to other offsets leave `irq` unchanged.
- R13: A read returns data one cycle later with `rsp_valid` high for exactly that cycle. An unlisted offset, or an offset with nonzero bits [1:0], reads zero. A write to such an offset changes no register and does not lower `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, accepted every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| flt_capture | input | 1 | Fault capture strobe from the translation datapath |
| flt_is_read | input | 1 | The faulting access was a read |
| flt_addr | input | 32 | Faulting I/O address |
| irq | output | 1 | Fault interrupt |
| xlate_en | output | 1 | Translation enable (control bit 0) |
| pt_base | output | 32 | Page-table base register |
| win_start | output | 32 | Start address of the translated window |

## Verification
A wrong mask or wrong forced bit shows on the first read-back after the write, exactly one cycle after the read request. For the control and base registers it also shows on `xlate_en`, `win_start` or `pt_base` in the cycle after the write. An interrupt flop that misses a capture, or clears on the wrong access, differs from the reference on the very next cycle. A capture that loses to a same-cycle bus write shows up in the next fault-status read. Sticky bits that clear in the mask ID register are caught by the read that follows a zero write.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;

  localparam int OFF_W      = 14;
  localparam int PAGE_SHIFT = 12;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_BASE,
    SEL_TLBFL,
    SEL_PGFL,
    SEL_FSTAT,
    SEL_FADDR,
    SEL_ARB_MB,
    SEL_SLOT,
    SEL_ARB_SB,
    SEL_MASKID
  } reg_sel_e;

  localparam logic [OFF_W-1:0] OFF_CTRL    = 14'h0000;
  localparam logic [OFF_W-1:0] OFF_BASE    = 14'h0004;
  localparam logic [OFF_W-1:0] OFF_TLBFL   = 14'h0014;
  localparam logic [OFF_W-1:0] OFF_PGFL    = 14'h0018;
  localparam logic [OFF_W-1:0] OFF_FSTAT   = 14'h1000;
  localparam logic [OFF_W-1:0] OFF_FADDR   = 14'h1004;
  localparam logic [OFF_W-1:0] OFF_ARB_MB  = 14'h1008;
  localparam logic [OFF_W-1:0] OFF_SLOT0   = 14'h1010;
  localparam logic [OFF_W-1:0] OFF_ARB_SB  = 14'h2000;
  localparam logic [OFF_W-1:0] OFF_MASKID  = 14'h3018;

  localparam logic [31:0] CTRL_KEEP   = 32'h0000_001D;
  localparam logic [31:0] BASE_KEEP   = 32'h07FF_FC00;
  localparam logic [31:0] ARB_MB_KEEP = 32'h801F_000F;
  localparam logic [31:0] ARB_MB_ONE  = 32'h0000_0001;
  localparam logic [31:0] ARB_SB_KEEP = 32'h001F_0000;
  localparam logic [31:0] ARB_SB_ONE  = 32'h0000_0008;
  localparam logic [31:0] FSTAT_KEEP  = 32'hFF0F_FFFF;
  localparam logic [31:0] SLOT_KEEP   = 32'h0001_0003;
  localparam logic [31:0] MASKID_SET  = 32'h00FF_FFFF;

  localparam logic [31:0] FS_ERR    = 32'h8000_0000;
  localparam logic [31:0] FS_LATE   = 32'h4000_0000;
  localparam logic [31:0] FS_RSVD   = 32'h0080_0000;
  localparam logic [31:0] FS_RDOP   = 32'h0004_0000;
  localparam logic [31:0] FS_AVALID = 32'h0002_0000;

  localparam logic [31:0] RST_ARB_MB = 32'h0000_0003;
  localparam logic [31:0] RST_ARB_SB = 32'h0000_0008;
  localparam logic [31:0] RST_MASKID = 32'h2300_0000;

  localparam logic [31:0] WIN_UNIT = 32'h0100_0000;

endpackage

// File: rtl/iommu_reg_decode.sv
module iommu_reg_decode
  import iommu_regs_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [SLOT_W-1:0] slot_idx
);

  localparam logic [ADDR_W-1:0] SLOT_LO = ADDR_W'(OFF_SLOT0);
  localparam logic [ADDR_W-1:0] SLOT_HI = ADDR_W'(int'(OFF_SLOT0) + 4 * NUM_SLOTS);

  logic [ADDR_W-1:0] slot_off;

  assign slot_off = addr - SLOT_LO;
  assign slot_idx = slot_off[SLOT_W+1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if      (addr == ADDR_W'(OFF_CTRL))   sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFF_BASE))   sel = SEL_BASE;
      else if (addr == ADDR_W'(OFF_TLBFL))  sel = SEL_TLBFL;
      else if (addr == ADDR_W'(OFF_PGFL))   sel = SEL_PGFL;
      else if (addr == ADDR_W'(OFF_FSTAT))  sel = SEL_FSTAT;
      else if (addr == ADDR_W'(OFF_FADDR))  sel = SEL_FADDR;
      else if (addr == ADDR_W'(OFF_ARB_MB)) sel = SEL_ARB_MB;
      else if (addr == ADDR_W'(OFF_ARB_SB)) sel = SEL_ARB_SB;
      else if (addr == ADDR_W'(OFF_MASKID)) sel = SEL_MASKID;
      else if (addr >= SLOT_LO && addr < SLOT_HI) sel = SEL_SLOT;
    end
  end

endmodule

// File: rtl/iommu_win_calc.sv
module iommu_win_calc
  import iommu_regs_pkg::*;
#(
  parameter int RNG_W = 3
) (
  input  logic [RNG_W-1:0] range_code,
  output logic [31:0]      win_start
);

  logic [31:0] win_size;

  always_comb begin
    win_size  = WIN_UNIT << range_code;
    win_start = 32'h0 - win_size;
  end

endmodule

// File: rtl/iommu_fault_ctl.sv
module iommu_fault_ctl
  import iommu_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stat,
  input  logic        wr_addr,
  input  logic        touch,
  input  logic [31:0] wdata,
  input  logic        cap,
  input  logic        cap_rd,
  input  logic [31:0] cap_addr,
  output logic [31:0] stat_q,
  output logic [31:0] addr_q,
  output logic        irq_q
);

  logic [31:0] cap_stat;

  assign cap_stat = FS_ERR | FS_LATE | FS_RSVD | FS_AVALID | (cap_rd ? FS_RDOP : 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= FS_RSVD;
      addr_q <= '0;
    end else if (cap) begin
      stat_q <= cap_stat;
      addr_q <= {cap_addr[31:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end else begin
      if (wr_stat) stat_q <= (wdata & FSTAT_KEEP) | FS_RSVD;
      if (wr_addr) addr_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (cap)   irq_q <= 1'b1;
    else if (touch) irq_q <= 1'b0;
  end

endmodule

// File: rtl/iommu_cfg_regs.sv
module iommu_cfg_regs
  import iommu_regs_pkg::*;
#(
  parameter int         ADDR_W    = 14,
  parameter int         NUM_SLOTS = 4,
  parameter logic [7:0] VERSION   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  input  logic              flt_capture,
  input  logic              flt_is_read,
  input  logic [31:0]       flt_addr,
  output logic              irq,
  output logic              xlate_en,
  output logic [31:0]       pt_base,
  output logic [31:0]       win_start
);

  localparam int          SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [31:0] VER_FIELD = {VERSION, 24'h0};

  reg_sel_e          sel;
  logic [SLOT_W-1:0] slot_idx;
  logic              wr_any;
  logic              rd_any;
  logic              fault_touch;
  logic [31:0]       rd_mux;

  logic [31:0] ctrl_q;
  logic [31:0] base_q;
  logic [31:0] tlbfl_q;
  logic [31:0] pgfl_q;
  logic [31:0] arb_mb_q;
  logic [31:0] arb_sb_q;
  logic [31:0] maskid_q;
  logic [31:0] fstat_q;
  logic [31:0] faddr_q;
  logic [31:0] slot_q [NUM_SLOTS];

  iommu_reg_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_dec (
    .addr     (req_addr),
    .sel      (sel),
    .slot_idx (slot_idx)
  );

  assign wr_any      = req_valid & req_write;
  assign rd_any      = req_valid & ~req_write;
  assign fault_touch = req_valid & ((sel == SEL_FSTAT) | (sel == SEL_FADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= VER_FIELD;
      base_q   <= '0;
      tlbfl_q  <= '0;
      pgfl_q   <= '0;
      arb_mb_q <= RST_ARB_MB;
      arb_sb_q <= RST_ARB_SB;
      maskid_q <= RST_MASKID;
    end else if (wr_any) begin
      case (sel)
        SEL_CTRL:   ctrl_q   <= (req_wdata & CTRL_KEEP) | VER_FIELD;
        SEL_BASE:   base_q   <= req_wdata & BASE_KEEP;
        SEL_TLBFL:  tlbfl_q  <= req_wdata;
        SEL_PGFL:   pgfl_q   <= req_wdata;
        SEL_ARB_MB: arb_mb_q <= (req_wdata & ARB_MB_KEEP) | ARB_MB_ONE;
        SEL_ARB_SB: arb_sb_q <= (req_wdata & ARB_SB_KEEP) | ARB_SB_ONE;
        SEL_MASKID: maskid_q <= maskid_q | (req_wdata & MASKID_SET);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_any && sel == SEL_SLOT && slot_idx == SLOT_W'(g))
        slot_q[g] <= req_wdata & SLOT_KEEP;
    end
  end

  iommu_fault_ctl u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stat  (wr_any & (sel == SEL_FSTAT)),
    .wr_addr  (wr_any & (sel == SEL_FADDR)),
    .touch    (fault_touch),
    .wdata    (req_wdata),
    .cap      (flt_capture),
    .cap_rd   (flt_is_read),
    .cap_addr (flt_addr),
    .stat_q   (fstat_q),
    .addr_q   (faddr_q),
    .irq_q    (irq)
  );

  iommu_win_calc #(.RNG_W(3)) u_win (
    .range_code (ctrl_q[4:2]),
    .win_start  (win_start)
  );

  always_comb begin
    case (sel)
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_BASE:   rd_mux = base_q;
      SEL_TLBFL:  rd_mux = tlbfl_q;
      SEL_PGFL:   rd_mux = pgfl_q;
      SEL_FSTAT:  rd_mux = fstat_q;
      SEL_FADDR:  rd_mux = faddr_q;
      SEL_ARB_MB: rd_mux = arb_mb_q;
      SEL_ARB_SB: rd_mux = arb_sb_q;
      SEL_MASKID: rd_mux = maskid_q;
      SEL_SLOT:   rd_mux = slot_q[slot_idx];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_any;
      rsp_data  <= rd_any ? rd_mux : 32'h0;
    end
  end

  assign xlate_en = ctrl_q[0];
  assign pt_base  = base_q;

endmodule

// File: rtl/iommu_cfg_regs_chk.sv
module iommu_cfg_regs_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              flt_capture,
  input logic              irq,
  input logic              xlate_en,
  input logic [31:0]       pt_base,
  input logic [31:0]       win_start
);

  assert_rd_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_spurious_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_ctrl_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(14'h0000)) |=> (xlate_en == $past(req_wdata[0])));

  assert_window_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start[23:0] == 24'h0) && win_start[31]);

  assert_base_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(14'h0004)) |=> (pt_base == ($past(req_wdata) & 32'h07FF_FC00)));

  assert_capture_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flt_capture |=> irq);

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flt_capture));

  assert_fault_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flt_capture && (req_addr == ADDR_W'(14'h1000) || req_addr == ADDR_W'(14'h1004))) |=> !irq);

endmodule

bind iommu_cfg_regs iommu_cfg_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .flt_capture (flt_capture),
  .irq         (irq),
  .xlate_en    (xlate_en),
  .pt_base     (pt_base),
  .win_start   (win_start)
);

// File: tb/tb_iommu_cfg_regs.sv
module tb_iommu_cfg_regs;

  localparam int         CLK_PERIOD = 10;
  localparam int         ADDR_W     = 14;
  localparam int         NUM_SLOTS  = 4;
  localparam logic [7:0] VER        = 8'h5A;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_data;
  logic              flt_capture = 1'b0;
  logic              flt_is_read = 1'b0;
  logic [31:0]       flt_addr = '0;
  logic              irq;
  logic              xlate_en;
  logic [31:0]       pt_base;
  logic [31:0]       win_start;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iommu_cfg_regs #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .VERSION(VER)) dut (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_data, .flt_capture, .flt_is_read, .flt_addr,
    .irq, .xlate_en, .pt_base, .win_start
  );

  // behavioural reference model
  logic [31:0] mreg [int];
  logic        m_irq;
  logic        m_rv;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_read(int off);
    if (mreg.exists(off)) return mreg[off];
    return 32'h0;
  endfunction

  function automatic void m_reset();
    mreg.delete();
    mreg['h0000] = {VER, 24'h0};
    mreg['h0004] = 0; mreg['h0014] = 0; mreg['h0018] = 0;
    mreg['h1000] = 32'h0080_0000; mreg['h1004] = 0;
    mreg['h1008] = 32'h3;
    for (int i = 0; i < NUM_SLOTS; i++) mreg['h1010 + 4*i] = 0;
    mreg['h2000] = 32'h8;
    mreg['h3018] = 32'h2300_0000;
    m_irq = 0; m_rv = 0; m_rd = 0;
  endfunction

  function automatic logic [31:0] m_wval(int off, logic [31:0] d);
    if (off == 'h0000) return (d & 32'h1D) | {VER, 24'h0};
    if (off == 'h0004) return d & 32'h07FF_FC00;
    if (off == 'h1000) return (d & 32'hFF0F_FFFF) | 32'h0080_0000;
    if (off == 'h1008) return (d & 32'h801F_000F) | 32'h1;
    if (off == 'h2000) return (d & 32'h001F_0000) | 32'h8;
    if (off == 'h3018) return mreg[off] | (d & 32'h00FF_FFFF);
    if (off >= 'h1010 && off < 'h1010 + 4*NUM_SLOTS) return d & 32'h0001_0003;
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int  a;
      bit  ftouch;
      a = int'(req_addr);
      ftouch = req_valid && (a == 'h1000 || a == 'h1004);
      m_rv = req_valid && !req_write;
      m_rd = m_rv ? m_read(a) : 32'h0;
      if (req_valid && req_write && mreg.exists(a) && !(flt_capture && ftouch))
        mreg[a] = m_wval(a, req_wdata);
      if (flt_capture) begin
        mreg['h1000] = 32'hC082_0000 | (flt_is_read ? 32'h0004_0000 : 32'h0);
        mreg['h1004] = {flt_addr[31:12], 12'h0};
        m_irq = 1;
      end else if (ftouch) m_irq = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rsp_valid == m_rv, "R13 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) check(rsp_data == m_rd, "R13 rsp_data", rsp_data, m_rd);
      check(irq == m_irq, "R12 irq", 32'(irq), 32'(m_irq));
      check(win_start == (32'hFFFF_FFFF << (24 + mreg['h0000][4:2])), "R3 win_start",
            win_start, 32'hFFFF_FFFF << (24 + mreg['h0000][4:2]));
      check(xlate_en == mreg['h0000][0], "R2 xlate_en", 32'(xlate_en), 32'(mreg['h0000][0]));
      check(pt_base == mreg['h0004], "R4 pt_base", pt_base, mreg['h0004]);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = ADDR_W'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid && rsp_data == exp, tag, rsp_data, exp);
  endtask

  task automatic capture(input logic [31:0] fa, input bit is_rd);
    @(negedge clk);
    flt_capture = 1; flt_is_read = is_rd; flt_addr = fa;
    @(negedge clk);
    flt_capture = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    check(irq == 0, "R1 irq reset", 32'(irq), 0);
    check(win_start == 32'hFF00_0000, "R1 win_start reset", win_start, 32'hFF00_0000);
    rd_chk('h0000, 32'h5A00_0000, "R1 ctrl reset");
    rd_chk('h1000, 32'h0080_0000, "R1 fstat reset");
    rd_chk('h1008, 32'h0000_0003, "R1 arb_mb reset");
    rd_chk('h2000, 32'h0000_0008, "R1 arb_sb reset");
    rd_chk('h3018, 32'h2300_0000, "R1 maskid reset");
    rd_chk('h0004, 32'h0, "R1 base reset");
    rd_chk('h1018, 32'h0, "R1 slot reset");
    // R2 control
    wr('h0000, 32'hFFFF_FFFF);
    check(xlate_en == 1, "R2 enable set", 32'(xlate_en), 1);
    rd_chk('h0000, 32'h5A00_001D, "R2 ctrl mask");
    wr('h0000, 32'h0);
    rd_chk('h0000, 32'h5A00_0000, "R2 ctrl clear");
    // R3 window
    for (int r = 0; r < 8; r++) begin
      wr('h0000, 32'(r) << 2);
      check(win_start == 32'h0 - (32'h0100_0000 << r), "R3 window", win_start, 32'h0 - (32'h0100_0000 << r));
    end
    check(win_start == 32'h8000_0000, "R3 window 2GB", win_start, 32'h8000_0000);
    // R4 base
    wr('h0004, 32'hFFFF_FFFF);
    check(pt_base == 32'h07FF_FC00, "R4 base port", pt_base, 32'h07FF_FC00);
    rd_chk('h0004, 32'h07FF_FC00, "R4 base read");
    // R5 flush
    wr('h0014, 32'hDEAD_BEEF);
    wr('h0018, 32'h1234_5678);
    rd_chk('h0014, 32'hDEAD_BEEF, "R5 tlb flush");
    rd_chk('h0018, 32'h1234_5678, "R5 page flush");
    // R6 arbiter enable
    wr('h1008, 32'h0);
    rd_chk('h1008, 32'h0000_0001, "R6 forced bit");
    wr('h1008, 32'hFFFF_FFFF);
    rd_chk('h1008, 32'h801F_000F, "R6 mask");
    // R7 arbitration enable
    wr('h2000, 32'h0);
    rd_chk('h2000, 32'h0000_0008, "R7 forced bit");
    wr('h2000, 32'hFFFF_FFFF);
    rd_chk('h2000, 32'h001F_0008, "R7 mask");
    // R8 fault registers by software
    wr('h1000, 32'h0);
    rd_chk('h1000, 32'h0080_0000, "R8 fstat forced");
    wr('h1000, 32'hFFFF_FFFF);
    rd_chk('h1000, 32'hFF8F_FFFF, "R8 fstat mask");
    wr('h1004, 32'hCAFE_F00D);
    rd_chk('h1004, 32'hCAFE_F00D, "R8 faddr raw");
    // R9 slots
    wr('h1014, 32'hFFFF_FFFF);
    wr('h1018, 32'h0000_0002);
    rd_chk('h1010, 32'h0, "R9 slot0 untouched");
    rd_chk('h1014, 32'h0001_0003, "R9 slot1 mask");
    rd_chk('h1018, 32'h0000_0002, "R9 slot2");
    rd_chk('h101C, 32'h0, "R9 slot3 untouched");
    // R10 mask ID sticky
    wr('h3018, 32'h0000_00F0);
    rd_chk('h3018, 32'h2300_00F0, "R10 set");
    wr('h3018, 32'h0000_000F);
    wr('h3018, 32'h0);
    rd_chk('h3018, 32'h2300_00FF, "R10 sticky");
    wr('h3018, 32'hFF00_0000);
    rd_chk('h3018, 32'h2300_00FF, "R10 top byte");
    // R11 capture
    capture(32'h1234_5678, 1'b1);
    check(irq == 1, "R11 irq raised", 32'(irq), 1);
    rd_chk('h1004, 32'h1234_5000, "R11 fault address");
    capture(32'hABCD_E123, 1'b0);
    rd_chk('h1000, 32'hC082_0000, "R11 write fault status");
    capture(32'h0000_1FFF, 1'b1);
    rd_chk('h1000, 32'hC086_0000, "R11 read fault status");
    // R12 clearing and priority
    check(irq == 0, "R12 cleared by read", 32'(irq), 0);
    capture(32'h0, 1'b0);
    rd_chk('h0000, 32'h5A00_001C, "R12 other read");
    check(irq == 1, "R12 other access keeps irq", 32'(irq), 1);
    wr('h1000, 32'h0);
    check(irq == 0, "R12 cleared by write", 32'(irq), 0);
    @(negedge clk);
    flt_capture = 1; flt_is_read = 0; flt_addr = 32'h7777_7777;
    req_valid = 1; req_write = 1; req_addr = 14'h1000; req_wdata = 32'h0;
    @(negedge clk);
    flt_capture = 0; req_valid = 0; req_write = 0;
    check(irq == 1, "R11 capture beats write irq", 32'(irq), 1);
    rd_chk('h1000, 32'hC082_0000, "R11 capture beats write");
    // R13 unlisted and misaligned
    capture(32'h0, 1'b0);
    wr('h0008, 32'hFFFF_FFFF);
    rd_chk('h0008, 32'h0, "R13 unlisted");
    wr('h0005, 32'hFFFF_FFFF);
    rd_chk('h0004, 32'h07FF_FC00, "R13 misaligned ignored");
    wr('h1001, 32'h0);
    check(irq == 1, "R13 misaligned keeps irq", 32'(irq), 1);
    rd_chk('h1002, 32'h0, "R13 misaligned read");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule